// File: doc/BRIEF.md
# I2C Byte Receiver with Clock Stretching

This block collects one data byte from an I2C data line and, if asked to, drives the acknowledge bit that follows it. The bus timing comes in from outside as single-cycle pulses. One pulse marks each rising edge of the clock line. The other marks a delayed version of each falling edge. The block also reads the sampled level of the real data line. It never generates the bus clock itself. It returns two open-drain style enables: one pulls the data line low and one holds the clock line low.

Received bytes pass through two stages. The first is the shift register that collects bits. The second is a holding register that the consumer reads through a valid/confirm handshake. A finished byte moves straight into the holding register, so the next byte can arrive at once. The block holds the clock low only when both stages are full. A separate bus-side clear returns the bit logic to idle. It keeps every byte already stored, so a controller can abandon a broken transfer without losing data it has not yet read.

Top module: `i2c_rx_byte_stage`

## Requirements
- R1: A pulse on `start_rd` while the block is idle with no pending byte arms a reception. A `start_rd` pulse at any other time is ignored: it neither restarts the bit count nor changes the byte being collected. Rising pulses that arrive while the block is idle shift nothing.
- R2: Each `scl_rise_p` pulse during a reception samples `sda_lvl`. The first sampled bit becomes bit DATA_W-1 of the byte and the last becomes bit 0, so bits arrive most significant first.
- R3: `sda_pull_low` never rises except in the cycle after a `scl_fall_dly_p` pulse. It is released on the delayed falling pulse that ends the acknowledge slot.
- R4: The acknowledge slot begins on the first `scl_fall_dly_p` after the last data bit. At that pulse `ack_gen` is sampled. A value of 1 pulls the data line low for the slot. A value of 0 leaves the line released, which sends a NACK.
- R5: If the holding register is empty, a completed byte appears on `byte_data` with `byte_valid` = 1 in the cycle after the last data rising pulse.
- R6: If a byte completes while `byte_valid` is still 1 and unconfirmed, the byte stays pending in the shift register. `scl_hold_low` is then 1 from the start of the acknowledge slot until the consumer confirms.
- R7: A `rd_confirm` pulse with no pending byte clears `byte_valid` on the next cycle. With a pending byte, the same pulse loads the pending byte into `byte_data`, keeps `byte_valid` = 1, and releases `scl_hold_low`.
- R8: `rx_done` is a one-cycle pulse in the cycle after the `scl_fall_dly_p` that closes the acknowledge slot.
- R9: A `bus_clr` pulse returns the bit logic to idle and releases both `sda_pull_low` and `scl_hold_low`. It leaves `byte_data`, `byte_valid` and any pending byte unchanged.
- R10: `rx_ready` is 1 exactly when no reception is in progress and no byte is pending.
- R11: While `rst_n` is low, all outputs are 0 except `rx_ready`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_clr | input | 1 | Clears only the bus-side bit logic |
| start_rd | input | 1 | Arms reception of one byte |
| scl_rise_p | input | 1 | One-cycle pulse on each clock line rising edge |
| scl_fall_dly_p | input | 1 | One-cycle pulse some cycles after each clock line falling edge |
| sda_lvl | input | 1 | Sampled level of the real data line |
| ack_gen | input | 1 | 1 sends ACK, 0 sends NACK after the byte |
| rd_confirm | input | 1 | Consumer has taken `byte_data` |
| sda_pull_low | output | 1 | Pull the data line low |
| scl_hold_low | output | 1 | Hold the clock line low (stretch) |
| rx_done | output | 1 | Byte and its acknowledge slot finished |
| byte_valid | output | 1 | `byte_data` holds an unread byte |
| byte_data | output | DATA_W | Holding register contents |
| rx_ready | output | 1 | Idle with no pending byte |

## Verification
The bench builds the block with its default DATA_W of 8. Every data pattern is therefore a real bus byte, and the position of each bit shows that bits are taken most significant first. Because the byte is eight bits wide, the acknowledge slot falls on the ninth clock. This makes it possible to check ACK and NACK values, a second byte arriving behind an unread one, and a bus clear that lands both in the middle of a byte and inside a stretched acknowledge slot.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_RECV     = 3'd1,
    PH_ACK_WAIT = 3'd2,
    PH_ACK_SLOT = 3'd3,
    PH_ACK_END  = 3'd4
  } rx_phase_e;

endpackage

// File: rtl/rxb_bit_engine.sv
module rxb_bit_engine
  import rxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clr,
  input  logic              start_rd,
  input  logic              scl_rise_p,
  input  logic              scl_fall_dly_p,
  input  logic              sda_lvl,
  input  logic              ack_gen,
  input  logic              pend_in,
  output rx_phase_e         phase_o,
  output logic [DATA_W-1:0] shreg_o,
  output logic [DATA_W-1:0] next_byte_o,
  output logic              byte_done_o,
  output logic              sda_pull_o,
  output logic              done_o
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  // Shift one bus bit in at the low end; earlier bits move toward the MSB.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                 input logic bit_in);
    logic [DATA_W-1:0] r;
    r = cur << 1;
    r[0] = bit_in;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_inc(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  rx_phase_e         phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              ack_q;
  logic              done_q;
  logic              arm_ok;

  assign arm_ok      = start_rd && (phase_q == PH_IDLE) && !pend_in;
  assign next_byte_o = shift_in(shreg_q, sda_lvl);
  assign byte_done_o = !bus_clr && (phase_q == PH_RECV) && scl_rise_p
                       && (cnt_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (bus_clr) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_IDLE: begin
            if (arm_ok) begin
              phase_q <= PH_RECV;
              cnt_q   <= '0;
            end
          end
          PH_RECV: begin
            if (scl_rise_p) begin
              shreg_q <= next_byte_o;
              cnt_q   <= cnt_inc(cnt_q);
              if (cnt_q == LAST_BIT) phase_q <= PH_ACK_WAIT;
            end
          end
          PH_ACK_WAIT: begin
            if (scl_fall_dly_p) begin
              phase_q <= PH_ACK_SLOT;
              ack_q   <= ack_gen;
            end
          end
          PH_ACK_SLOT: begin
            if (scl_rise_p) phase_q <= PH_ACK_END;
          end
          PH_ACK_END: begin
            if (scl_fall_dly_p) begin
              phase_q <= PH_IDLE;
              ack_q   <= 1'b0;
              done_q  <= 1'b1;
              cnt_q   <= '0;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o    = phase_q;
  assign shreg_o    = shreg_q;
  assign sda_pull_o = ack_q;
  assign done_o     = done_q;

endmodule

// File: rtl/rxb_hold_stage.sv
module rxb_hold_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] next_byte,
  input  logic [DATA_W-1:0] pend_src,
  input  logic              rd_confirm,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pend_o
);

  logic              valid_q;
  logic              pend_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else if (byte_done) begin
      if (!valid_q || rd_confirm) begin
        data_q  <= next_byte;
        valid_q <= 1'b1;
      end else begin
        pend_q <= 1'b1;
      end
    end else if (rd_confirm) begin
      if (pend_q) begin
        data_q  <= pend_src;
        valid_q <= 1'b1;
        pend_q  <= 1'b0;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign pend_o  = pend_q;

endmodule

// File: rtl/rxb_flow_ctl.sv
module rxb_flow_ctl
  import rxb_pkg::*;
(
  input  rx_phase_e phase,
  input  logic      pend,
  output logic      scl_hold_o,
  output logic      ready_o
);

  assign scl_hold_o = pend && (phase == PH_ACK_SLOT);
  assign ready_o    = (phase == PH_IDLE) && !pend;

endmodule

// File: rtl/i2c_rx_byte_stage.sv
module i2c_rx_byte_stage
  import rxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clr,
  input  logic              start_rd,
  input  logic              scl_rise_p,
  input  logic              scl_fall_dly_p,
  input  logic              sda_lvl,
  input  logic              ack_gen,
  input  logic              rd_confirm,
  output logic              sda_pull_low,
  output logic              scl_hold_low,
  output logic              rx_done,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              rx_ready
);

  rx_phase_e         phase_w;
  logic [DATA_W-1:0] shreg_w;
  logic [DATA_W-1:0] next_byte_w;
  logic              byte_done_w;
  logic              pend_w;

  rxb_bit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_clr        (bus_clr),
    .start_rd       (start_rd),
    .scl_rise_p     (scl_rise_p),
    .scl_fall_dly_p (scl_fall_dly_p),
    .sda_lvl        (sda_lvl),
    .ack_gen        (ack_gen),
    .pend_in        (pend_w),
    .phase_o        (phase_w),
    .shreg_o        (shreg_w),
    .next_byte_o    (next_byte_w),
    .byte_done_o    (byte_done_w),
    .sda_pull_o     (sda_pull_low),
    .done_o         (rx_done)
  );

  rxb_hold_stage #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_done  (byte_done_w),
    .next_byte  (next_byte_w),
    .pend_src   (shreg_w),
    .rd_confirm (rd_confirm),
    .valid_o    (byte_valid),
    .data_o     (byte_data),
    .pend_o     (pend_w)
  );

  rxb_flow_ctl u_flow (
    .phase      (phase_w),
    .pend       (pend_w),
    .scl_hold_o (scl_hold_low),
    .ready_o    (rx_ready)
  );

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_clr,
  input logic              scl_fall_dly_p,
  input logic              rd_confirm,
  input logic              sda_pull_low,
  input logic              scl_hold_low,
  input logic              rx_done,
  input logic              byte_valid,
  input logic [DATA_W-1:0] byte_data,
  input logic              rx_ready,
  input logic              pend,
  input logic              byte_done
);

  // R3: data line is only taken low right after a delayed falling pulse
  p_sda_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> $past(scl_fall_dly_p));

  // R6: stretching only happens with both stages full
  p_stretch_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_low |-> (byte_valid && pend));

  // R7: plain confirm empties the holding register
  p_confirm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_confirm && byte_valid && !pend && !byte_done) |=> !byte_valid);

  // R7: confirm with a pending byte refills and releases the stretch
  p_confirm_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_confirm && pend) |=> (byte_valid && !scl_hold_low));

  // R8: done lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R9: bus clear releases the lines and keeps stored data
  p_bus_clr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_clr && !rd_confirm) |=> (!sda_pull_low && !scl_hold_low
                                  && $stable(byte_data) && $stable(byte_valid)));

  // R10: ready means nothing is driven and nothing is pending
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (!sda_pull_low && !scl_hold_low && !pend));

endmodule

bind i2c_rx_byte_stage rxb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_clr        (bus_clr),
  .scl_fall_dly_p (scl_fall_dly_p),
  .rd_confirm     (rd_confirm),
  .sda_pull_low   (sda_pull_low),
  .scl_hold_low   (scl_hold_low),
  .rx_done        (rx_done),
  .byte_valid     (byte_valid),
  .byte_data      (byte_data),
  .rx_ready       (rx_ready),
  .pend           (pend_w),
  .byte_done      (byte_done_w)
);

// File: tb/i2c_rx_byte_stage_tb.sv
module i2c_rx_byte_stage_tb;

  localparam int DATA_W = 8;
  // {ack_gen, data byte}
  localparam logic [8:0] VEC [6] = '{9'h1A5, 9'h03C, 9'h1FF, 9'h000, 9'h181, 9'h07E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clr = 1'b0, start_rd = 1'b0, scl_rise_p = 1'b0, scl_fall_dly_p = 1'b0;
  logic sda_lvl = 1'b1, ack_gen = 1'b0, rd_confirm = 1'b0;
  logic sda_pull_low, scl_hold_low, rx_done, byte_valid, rx_ready;
  logic [DATA_W-1:0] byte_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2c_rx_byte_stage #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_clr(bus_clr), .start_rd(start_rd),
    .scl_rise_p(scl_rise_p), .scl_fall_dly_p(scl_fall_dly_p), .sda_lvl(sda_lvl),
    .ack_gen(ack_gen), .rd_confirm(rd_confirm), .sda_pull_low(sda_pull_low),
    .scl_hold_low(scl_hold_low), .rx_done(rx_done), .byte_valid(byte_valid),
    .byte_data(byte_data), .rx_ready(rx_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic arm_rx();
    start_rd = 1'b1; tick(); start_rd = 1'b0;
  endtask

  task automatic fall();
    scl_fall_dly_p = 1'b1; tick(); scl_fall_dly_p = 1'b0;
  endtask

  task automatic rise(input logic b);
    sda_lvl = b; scl_rise_p = 1'b1; tick(); scl_rise_p = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      fall(); tick(); rise(b[i]); tick();
    end
  endtask

  task automatic confirm_rd();
    rd_confirm = 1'b1; tick(); rd_confirm = 1'b0;
  endtask

  task automatic finish_ack();
    tick(); rise(1'b1); tick(); fall();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a;
    repeat (3) tick();
    // R11 reset state
    chk("R11 ready in reset", rx_ready, 1);
    chk("R11 valid in reset", byte_valid, 0);
    chk("R11 sda in reset", sda_pull_low, 0);
    chk("R11 stretch in reset", scl_hold_low, 0);
    chk("R11 done in reset", rx_done, 0);
    rst_n = 1'b1;
    tick();

    // R1: rising pulses while idle shift nothing
    rise(1'b1); tick(); rise(1'b0); tick();
    chk("R1 idle rises ignored", byte_valid, 0);
    chk("R1 still ready", rx_ready, 1);

    // table-driven bytes
    for (int k = 0; k < 6; k++) begin
      {a, d} = VEC[k];
      ack_gen = a;
      chk("R10 ready before byte", rx_ready, 1);
      arm_rx();
      chk("R10 busy after arm", rx_ready, 0);
      send_bits(d, 7, 0);
      chk("R5 valid after last bit", byte_valid, 1);
      chk("R2 byte msb first", byte_data, d);
      chk("R3 no drive before fall", sda_pull_low, 0);
      fall();
      chk("R4 ack level", sda_pull_low, a);
      chk("R6 no stretch when empty", scl_hold_low, 0);
      tick(); rise(1'b1);
      chk("R8 no done yet", rx_done, 0);
      chk("R4 ack held", sda_pull_low, a);
      tick(); fall();
      chk("R8 done pulse", rx_done, 1);
      chk("R3 released", sda_pull_low, 0);
      tick();
      chk("R8 done single", rx_done, 0);
      confirm_rd();
      chk("R7 confirm clears", byte_valid, 0);
    end

    // R6/R7: second byte behind an unread one
    ack_gen = 1'b1;
    arm_rx(); send_bits(8'h5A, 7, 0); fall(); finish_ack();
    tick();
    chk("R5 first byte held", byte_data, 8'h5A);
    arm_rx(); send_bits(8'hC3, 7, 0);
    chk("R6 holding unchanged", byte_data, 8'h5A);
    chk("R10 not ready pending", rx_ready, 0);
    chk("R6 no stretch before slot", scl_hold_low, 0);
    fall();
    chk("R6 stretch in slot", scl_hold_low, 1);
    chk("R4 ack while stretched", sda_pull_low, 1);
    tick(); tick();
    chk("R6 stretch persists", scl_hold_low, 1);
    confirm_rd();
    chk("R7 pending loaded", byte_data, 8'hC3);
    chk("R7 valid kept", byte_valid, 1);
    chk("R7 stretch released", scl_hold_low, 0);
    finish_ack();
    chk("R8 done after stretch", rx_done, 1);
    tick();
    confirm_rd();
    chk("R7 empty after confirm", byte_valid, 0);

    // R9: bus clear mid-byte and inside a stretched slot
    arm_rx(); send_bits(8'h96, 7, 0); fall(); finish_ack(); tick();
    arm_rx(); send_bits(8'h3C, 7, 4);
    bus_clr = 1'b1; tick(); bus_clr = 1'b0;
    chk("R9 idle after clear", rx_ready, 1);
    chk("R9 data kept", byte_data, 8'h96);
    chk("R9 valid kept", byte_valid, 1);
    arm_rx(); send_bits(8'h3C, 7, 0); fall();
    chk("R6 stretch before clear", scl_hold_low, 1);
    bus_clr = 1'b1; tick(); bus_clr = 1'b0;
    chk("R9 sda released", sda_pull_low, 0);
    chk("R9 stretch released", scl_hold_low, 0);
    chk("R9 data kept in slot", byte_data, 8'h96);
    chk("R10 pending blocks ready", rx_ready, 0);
    confirm_rd();
    chk("R9 pending byte kept", byte_data, 8'h3C);
    confirm_rd();
    chk("R7 drained", byte_valid, 0);
    chk("R10 ready again", rx_ready, 1);

    // R1: arm during a reception is ignored
    ack_gen = 1'b0;
    arm_rx(); send_bits(8'hB4, 7, 4);
    arm_rx(); send_bits(8'hB4, 3, 0);
    chk("R1 re-arm ignored data", byte_data, 8'hB4);
    chk("R1 re-arm ignored valid", byte_valid, 1);
    fall();
    chk("R4 nack released", sda_pull_low, 0);
    finish_ack();
    chk("R8 done nack", rx_done, 1);
    tick(); confirm_rd();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule